// File: doc/BRIEF.md
# Priority-Threshold Interrupt Arbiter

This block picks one winner among up to 64 interrupt sources that are already requesting service. The surrounding controller has already filtered each request for pending, enabled and normal (not fast) type. Each source has a 4-bit priority. The 64 priorities arrive packed into eight 32-bit words. The source with the highest priority wins. When several requesting sources share the top priority, the one with the highest number wins.

The block also compares the requests against a 5-bit threshold and raises an interrupt-request flag. The flag is set when at least one requesting source has a priority strictly above the threshold. The all-ones threshold value is a bypass: with it, the flag follows the OR of all requests.

All outputs are registered one clock after the inputs. The outputs are the winner number, the winner's priority, a valid flag, the interrupt-request flag and a packed 32-bit status word. Everything else stays in the controller: updating the requests, decoding the register bus, and clearing the source that was acknowledged.

Top module: `prio_thresh_arb`

## Requirements
- R1: The priority of source n is the 4-bit field starting at bit 4*(n mod 8) of priority word n/8. The priority words are concatenated with word k at bits 32k+31:32k of `prio_words_i`, so source n occupies bits 4n+3:4n.
- R2: When any request is set, `win_idx_o` is a requesting source and no other requesting source has a higher priority.
- R3: Among requesting sources that share the highest priority, the highest-numbered source wins.
- R4: A single request with priority 0 still produces `win_valid_o`=1, with that source number and priority 0.
- R5: With no request set, `win_valid_o`=0, `win_idx_o`=0, `win_prio_o`=0 and `result_o`=32'hFFFF_FFFF.
- R6: When `thresh_i` is 5'h1F, `irq_o` equals the OR of all request bits, whatever the priorities.
- R7: For any other threshold, `irq_o` is 1 exactly when some requesting source has a priority strictly greater than `thresh_i`. A priority equal to the threshold does not count, and thresholds from 15 to 30 never raise the flag.
- R8: When a winner exists, `result_o` holds the winner number in bits 21:16 and its priority in bits 3:0. All other bits are zero.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. A synchronous active-high reset sets the outputs to the R5 idle values with `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 64 | Filtered request vector, bit n = source n |
| prio_words_i | input | 256 | Eight 32-bit priority words, word k at bits 32k+31:32k |
| thresh_i | input | 5 | Threshold; 5'h1F bypasses the priority test |
| win_idx_o | output | 6 | Registered winner number |
| win_prio_o | output | 4 | Registered winner priority |
| win_valid_o | output | 1 | Registered: a winner exists |
| irq_o | output | 1 | Registered interrupt-request flag |
| result_o | output | 32 | Registered packed winner word, all ones when idle |

## Verification
The bench sets up ties at the top priority, where a tree that favours the lower index would report the wrong source. It drives a lone priority-0 request, which a design that treats priority 0 as "no request" would report as idle. It puts the threshold exactly equal to the best priority, just below it, in the 15 to 30 range, and at the 5'h1F bypass, which separates a strict comparison from a non-strict one and a working bypass from a missing one. It also writes distinct priorities into every nibble position to catch a wrong field position, and checks that outputs do not change before the clock edge that captures the new inputs.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    parameter int NUM_SRC   = 64;
    parameter int PRIO_W    = 4;
    parameter int WORD_W    = 32;

    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int PER_WORD  = WORD_W / PRIO_W;
    localparam int NUM_WORDS = NUM_SRC / PER_WORD;
    localparam int THR_W     = PRIO_W + 1;
    localparam int RES_W     = 32;
    localparam int RES_IDX_LSB = 16;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    localparam cand_t CAND_NONE = '{valid: 1'b0, idx: '0, prio: '0};

    // hi holds only higher source numbers than lo; equal priority goes to hi
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        cand_t r;
        if (!hi.valid)
            r = lo;
        else if (!lo.valid)
            r = hi;
        else if (hi.prio >= lo.prio)
            r = hi;
        else
            r = lo;
        return r;
    endfunction

    function automatic logic [RES_W-1:0] pack_result(input cand_t c);
        logic [RES_W-1:0] w;
        w = '0;
        if (c.valid) begin
            w[RES_IDX_LSB +: IDX_W] = c.idx;
            w[0 +: PRIO_W]          = c.prio;
        end else begin
            w = '1;
        end
        return w;
    endfunction

endpackage

// File: rtl/prio_unpack.sv
module prio_unpack
    import prio_arb_pkg::*;
(
    input  logic [NUM_WORDS*WORD_W-1:0]  words_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o
);
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam int WSEL = n / PER_WORD;
        localparam int FSEL = (n % PER_WORD) * PRIO_W;
        assign prio_o[n] = words_i[WSEL*WORD_W + FSEL +: PRIO_W];
    end
endmodule

// File: rtl/prio_tree.sv
module prio_tree
    import prio_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    output cand_t                          win_o
);
    cand_t leaf [NUM_SRC];

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_leaf
        assign leaf[n].valid = req_i[n];
        assign leaf[n].idx   = req_i[n] ? IDX_W'(n) : '0;
        assign leaf[n].prio  = req_i[n] ? prio_i[n] : '0;
    end

    always_comb begin
        cand_t work [NUM_SRC];
        for (int j = 0; j < NUM_SRC; j++)
            work[j] = leaf[j];
        for (int span = NUM_SRC / 2; span >= 1; span = span / 2) begin
            for (int j = 0; j < span; j++)
                work[j] = pick(work[2*j], work[2*j+1]);
        end
        win_o = work[0];
    end
endmodule

// File: rtl/thresh_detect.sv
module thresh_detect
    import prio_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0]             req_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [THR_W-1:0]               thresh_i,
    output logic                           irq_o
);
    logic [NUM_SRC-1:0] above;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_cmp
        assign above[n] = req_i[n] && ({1'b0, prio_i[n]} > thresh_i);
    end

    assign irq_o = (&thresh_i) ? (|req_i) : (|above);
endmodule

// File: rtl/prio_thresh_arb.sv
module prio_thresh_arb
    import prio_arb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            req_i,
    input  logic [NUM_WORDS*WORD_W-1:0]   prio_words_i,
    input  logic [THR_W-1:0]              thresh_i,
    output logic [IDX_W-1:0]              win_idx_o,
    output logic [PRIO_W-1:0]             win_prio_o,
    output logic                          win_valid_o,
    output logic                          irq_o,
    output logic [RES_W-1:0]              result_o
);
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    cand_t win_d;
    cand_t win_q;
    logic  irq_d;
    logic  irq_q;
    logic [RES_W-1:0] res_q;

    prio_unpack u_unpack (
        .words_i (prio_words_i),
        .prio_o  (prio)
    );

    prio_tree u_tree (
        .req_i  (req_i),
        .prio_i (prio),
        .win_o  (win_d)
    );

    thresh_detect u_thr (
        .req_i    (req_i),
        .prio_i   (prio),
        .thresh_i (thresh_i),
        .irq_o    (irq_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= CAND_NONE;
            irq_q <= 1'b0;
            res_q <= '1;
        end else begin
            win_q <= win_d;
            irq_q <= irq_d;
            res_q <= pack_result(win_d);
        end
    end

    assign win_idx_o   = win_q.idx;
    assign win_prio_o  = win_q.prio;
    assign win_valid_o = win_q.valid;
    assign irq_o       = irq_q;
    assign result_o    = res_q;
endmodule

// File: rtl/prio_thresh_arb_chk.sv
module prio_thresh_arb_chk
    import prio_arb_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_SRC-1:0]          req_i,
    input logic [NUM_WORDS*WORD_W-1:0] prio_words_i,
    input logic [THR_W-1:0]            thresh_i,
    input logic [IDX_W-1:0]            win_idx_o,
    input logic [PRIO_W-1:0]           win_prio_o,
    input logic                        win_valid_o,
    input logic                        irq_o,
    input logic [RES_W-1:0]            result_o
);
    logic [NUM_SRC-1:0]          req_d;
    logic [NUM_WORDS*WORD_W-1:0] words_d;

    always_ff @(posedge clk) begin
        req_d   <= req_i;
        words_d <= prio_words_i;
    end

    AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (win_valid_o == ($past(req_i) != '0)));                       // R9

    AST_IDLE_VALUES: assert property (@(posedge clk) disable iff (rst)
        !win_valid_o |-> (result_o == '1 && win_idx_o == '0 && win_prio_o == '0)); // R5

    AST_BYPASS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (thresh_i == '1) |=> (irq_o == $past(|req_i)));                        // R6

    AST_IRQ_NEEDS_WINNER: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> win_valid_o);                                                // R7

    AST_WINNER_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> req_d[win_idx_o]);                                     // R2

    AST_WINNER_FIELD: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> (win_prio_o == words_d[win_idx_o*PRIO_W +: PRIO_W]));  // R1

    AST_RESULT_LAYOUT: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> (result_o[RES_IDX_LSB +: IDX_W] == win_idx_o
                         && result_o[PRIO_W-1:0] == win_prio_o
                         && result_o[RES_W-1:RES_IDX_LSB+IDX_W] == '0
                         && result_o[RES_IDX_LSB-1:PRIO_W] == '0));            // R8
endmodule

bind prio_thresh_arb prio_thresh_arb_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .prio_words_i (prio_words_i),
    .thresh_i     (thresh_i),
    .win_idx_o    (win_idx_o),
    .win_prio_o   (win_prio_o),
    .win_valid_o  (win_valid_o),
    .irq_o        (irq_o),
    .result_o     (result_o)
);

// File: tb/tb_prio_thresh_arb.sv
`timescale 1ns/1ps
module tb_prio_thresh_arb;
    logic         clk = 1'b0;
    logic         rst;
    logic [63:0]  req;
    logic [255:0] words;
    logic [4:0]   thr;
    logic [5:0]   win_idx;
    logic [3:0]   win_prio;
    logic         win_valid;
    logic         irq;
    logic [31:0]  result;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    prio_thresh_arb dut (
        .clk(clk), .rst(rst), .req_i(req), .prio_words_i(words),
        .thresh_i(thr), .win_idx_o(win_idx), .win_prio_o(win_prio),
        .win_valid_o(win_valid), .irq_o(irq), .result_o(result)
    );

    function automatic logic [3:0] fld(input logic [255:0] w, input int n);
        return w[4*n +: 4];
    endfunction

    // expected: highest priority, ties to the highest number
    function automatic void ref_arb(input logic [63:0] r, input logic [255:0] w,
                                    output bit v, output int idx, output int pr);
        v = 0; idx = 0; pr = 0;
        for (int i = 0; i < 64; i++) begin
            if (r[i] && (!v || int'(fld(w, i)) >= pr)) begin
                v = 1; idx = i; pr = int'(fld(w, i));
            end
        end
    endfunction

    function automatic bit ref_irq(input logic [63:0] r, input logic [255:0] w,
                                   input logic [4:0] t);
        bit f = 0;
        if (t == 5'h1F) return |r;
        for (int i = 0; i < 64; i++)
            if (r[i] && int'(fld(w, i)) > int'(t)) f = 1;
        return f;
    endfunction

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic apply(input logic [63:0] r, input logic [255:0] w, input logic [4:0] t,
                         input string tag);
        bit v; int idx; int pr; logic [31:0] er;
        req = r; words = w; thr = t;
        ref_arb(r, w, v, idx, pr);
        er = v ? {10'b0, 6'(idx), 12'b0, 4'(pr)} : 32'hFFFF_FFFF;
        @(negedge clk);
        chk({tag, " R2"}, "valid", longint'(win_valid), longint'(v));
        chk({tag, " R3"}, "idx", longint'(win_idx), longint'(idx));
        chk({tag, " R1"}, "prio", longint'(win_prio), longint'(pr));
        chk({tag, " R7"}, "irq", longint'(irq), longint'(ref_irq(r, w, t)));
        chk({tag, " R8"}, "result", longint'(result), longint'(er));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [255:0] w;
        void'($urandom(32'd2718));
        rst = 1'b1; req = '1; words = '1; thr = 5'd0;
        repeat (3) @(negedge clk);
        // R9 reset state, R5 idle values
        chk("R9", "reset valid", longint'(win_valid), 0);
        chk("R9", "reset irq", longint'(irq), 0);
        chk("R5", "reset result", longint'(result), 32'hFFFF_FFFF);
        rst = 1'b0;

        // R5 no requests
        apply(64'd0, {64{4'h9}}, 5'd0, "R5 none");
        chk("R5", "idle idx", longint'(win_idx), 0);
        // R4 lone priority-zero request
        apply(64'd1, 256'd0, 5'd3, "R4 lone p0 src0");
        chk("R4", "valid", longint'(win_valid), 1);
        apply(64'h8000_0000_0000_0000, 256'd0, 5'd0, "R4 lone p0 src63");
        // R3 ties: all equal, highest wins
        apply('1, {64{4'h5}}, 5'd4, "R3 all tie");
        chk("R3", "tie idx", longint'(win_idx), 63);
        w = '0; w[4*10 +: 4] = 4'hC; w[4*40 +: 4] = 4'hC; w[4*41 +: 4] = 4'hB;
        apply((64'd1 << 10) | (64'd1 << 40) | (64'd1 << 41), w, 5'd11, "R3 split tie");
        chk("R3", "split idx", longint'(win_idx), 40);
        // R7 strictness at the boundary
        apply(64'd1 << 7, {64{4'h6}}, 5'd6, "R7 equal thr");
        chk("R7", "equal thr irq", longint'(irq), 0);
        apply(64'd1 << 7, {64{4'h6}}, 5'd5, "R7 thr below");
        chk("R7", "below thr irq", longint'(irq), 1);
        apply('1, {64{4'hF}}, 5'd15, "R7 thr 15");
        chk("R7", "thr15 irq", longint'(irq), 0);
        apply('1, {64{4'hF}}, 5'd30, "R7 thr 30");
        // R6 bypass with priority zero
        apply(64'd1 << 33, 256'd0, 5'h1F, "R6 bypass");
        chk("R6", "bypass irq", longint'(irq), 1);
        apply(64'd0, 256'd0, 5'h1F, "R6 bypass idle");
        // R1 every nibble position, distinct per source
        for (int i = 0; i < 64; i++) w[4*i +: 4] = 4'(i * 7 + 3);
        for (int i = 0; i < 64; i += 5) apply(64'd1 << i, w, 5'd0, "R1 field");
        // R9 latency: output holds until the capturing edge
        apply(64'd1 << 2, {64{4'h1}}, 5'd0, "R9 pre");
        req = 64'd1 << 50;
        #1;
        chk("R9", "held idx", longint'(win_idx), 2);
        @(negedge clk);
        chk("R9", "new idx", longint'(win_idx), 50);

        // constrained random
        for (int it = 0; it < 400; it++) begin
            logic [63:0] r;
            logic [4:0]  t;
            for (int k = 0; k < 8; k++) w[32*k +: 32] = $urandom;
            r = {$urandom, $urandom};
            if (it % 3 == 1) r = r & {$urandom, $urandom} & {$urandom, $urandom};
            if (it % 7 == 0) r = '0;
            if (it % 5 == 0) t = 5'h1F; else t = 5'($urandom % 20);
            apply(r, w, t, "RND");
        end

        rst = 1'b1;
        @(negedge clk);
        chk("R9", "reset again", longint'(result), 32'hFFFF_FFFF);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule